// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block keeps a small associative record of loads that were hoisted above stores that might write the same memory. When such an early load issues, it claims an entry keyed by the number of its destination register, and the entry stores the byte address and the access width. Every store that follows is compared in one cycle against all live entries, and any entry whose bytes it touches is dropped.

When the program reaches the point where the loaded value is consumed, a check names the same register. If its entry is still live, the early load was safe and the hit output rises. If the entry is gone, because a store overlapped it, a later claim displaced it, or a flush cleared the table, the rollback output rises so that recovery code can redo the load. A flush input empties the table, for example on a change of thread context. Data values and the memory system are not part of this block.

Top module: `spec_addr_table`

## Requirements
- R1: After reset the table holds no live entries, checkHit and checkRollback are low, and a check of any register answers with rollback.
- R2: A check of a register whose entry is live answers with checkHit high and checkRollback low on the first clock edge after checkValid is sampled, and the entry stays live, so a repeated check hits again.
- R3: A check of a register with no live entry raises checkRollback for exactly one cycle, with checkHit low. Neither output is high in a cycle that does not follow a sampled check.
- R4: Size codes are 0, 1, 2 and 3 for 1, 2, 4 and 8 bytes, and accesses are naturally aligned, so an access covers the size-aligned block that contains its address. A store whose block overlaps an entry's block, whether the store is wider, narrower or equal, kills that entry.
- R5: A store whose block does not overlap an entry's block, including an adjacent block, leaves the entry live.
- R6: A claim for a register that already owns an entry overwrites that entry, so only the newest address is tracked for that register.
- R7: With all 32 entries live and a claim for a new register, the victim is chosen round robin, starting at entry 0 after reset or flush and advancing by one only on each round-robin replacement; when the table was filled from empty, entry n holds the n-th claim.
- R8: A store and a claim in the same cycle act store first: the new entry survives even when its block overlaps the store, while older overlapping entries are killed.
- R9: A check in the same cycle as a store sees the store: if that store overlaps the checked entry, the check answers with rollback.
- R10: Flush clears all entries and resets the round-robin position; a claim in the same cycle as a flush is dropped, and a check in the same cycle as a flush answers with rollback.
- R11: When the table has a free entry, a claim for a new register takes the lowest-numbered free entry (including one freed by a store in the same cycle) and does not move the round-robin position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| flushAll | input | 1 | Empty the whole table |
| allocValid | input | 1 | Early load claims an entry |
| allocReg | input | REG_W | Destination register of the early load |
| allocAddr | input | ADDR_W | Byte address of the early load |
| allocSize | input | 2 | Size code of the early load |
| storeValid | input | 1 | A store is snooped this cycle |
| storeAddr | input | ADDR_W | Byte address of the store |
| storeSize | input | 2 | Size code of the store |
| checkValid | input | 1 | Check of one register's entry |
| checkReg | input | REG_W | Register named by the check |
| checkHit | output | 1 | Registered: speculation held |
| checkRollback | output | 1 | Registered: recovery needed |

## Verification
A store can arrive in the same cycle as a claim or as a check, and the ordering between them decides the outcome. The bench drives a store and a claim to the same block in one cycle and then checks that the new register hits while an older register on that block rolls back; it also drives a store and a check together and expects rollback from that very check. Flush is likewise combined with a claim and a check in one cycle, and both must act as if the table were already empty.

// File: rtl/spec_tbl_pkg.sv
package spec_tbl_pkg;

  // Widest entry index the strobe struct can carry (tables up to 256 entries).
  localparam int unsigned IDX_MAX_W = 8;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } accSize_e;

  // Control to datapath strobes for one cycle.
  typedef struct packed {
    logic                 wrEn;
    logic [IDX_MAX_W-1:0] wrIdx;
    logic                 flush;
  } ctrlStrobe_t;

endpackage

// File: rtl/spec_tbl_entries.sv
module spec_tbl_entries
  import spec_tbl_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned REG_W   = 7,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [REG_W-1:0]   allocReg,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic [1:0]         allocSize,
  input  logic               storeValid,
  input  logic [ADDR_W-1:0]  storeAddr,
  input  logic [1:0]         storeSize,
  input  logic [REG_W-1:0]   checkReg,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] allocTagVec,
  output logic [ENTRIES-1:0] freeVec,
  output logic [ENTRIES-1:0] checkVec
);

  logic [ENTRIES-1:0] validQ;
  logic [REG_W-1:0]   tagQ  [ENTRIES];
  logic [ADDR_W-1:0]  addrQ [ENTRIES];
  logic [1:0]         sizeQ [ENTRIES];
  logic [ENTRIES-1:0] storeKill;
  logic [ENTRIES-1:0] liveVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic [1:0]        maxSz;
    logic [ADDR_W-1:0] blkMask;
    logic              wrHere;

    // Two aligned power-of-two blocks overlap iff they agree above the larger size.
    always_comb begin
      maxSz   = (sizeQ[i] > storeSize) ? sizeQ[i] : storeSize;
      blkMask = ~((ADDR_W'(1) << maxSz) - ADDR_W'(1));
    end

    assign storeKill[i]   = storeValid && validQ[i] &&
                            (((addrQ[i] ^ storeAddr) & blkMask) == '0);
    assign liveVec[i]     = validQ[i] && !storeKill[i] && !strb.flush;
    assign allocTagVec[i] = validQ[i] && (tagQ[i] == allocReg);
    assign checkVec[i]    = liveVec[i] && (tagQ[i] == checkReg);
    assign freeVec[i]     = !liveVec[i];
    assign wrHere         = strb.wrEn && (strb.wrIdx == IDX_MAX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        tagQ[i]   <= '0;
        addrQ[i]  <= '0;
        sizeQ[i]  <= '0;
      end else if (wrHere) begin
        validQ[i] <= 1'b1;
        tagQ[i]   <= allocReg;
        addrQ[i]  <= allocAddr;
        sizeQ[i]  <= allocSize;
      end else begin
        validQ[i] <= liveVec[i];
      end
    end
  end

  assign validVec = validQ;

endmodule

// File: rtl/spec_tbl_ctrl.sv
module spec_tbl_ctrl
  import spec_tbl_pkg::*;
#(
  parameter int unsigned ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushAll,
  input  logic               allocValid,
  input  logic               checkValid,
  input  logic [ENTRIES-1:0] allocTagVec,
  input  logic [ENTRIES-1:0] freeVec,
  input  logic [ENTRIES-1:0] checkVec,
  output ctrlStrobe_t        strb,
  output logic               checkHit,
  output logic               checkRollback
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] rrQ;
  logic [IDX_W-1:0] tagIdx;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] pickIdx;
  logic             useRr;

  always_comb begin
    tagIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (allocTagVec[i]) tagIdx  = IDX_W'(i);
      if (freeVec[i])     freeIdx = IDX_W'(i);
    end
  end

  always_comb begin
    useRr   = 1'b0;
    if (|allocTagVec)  pickIdx = tagIdx;
    else if (|freeVec) pickIdx = freeIdx;
    else begin
      pickIdx = rrQ;
      useRr   = 1'b1;
    end
  end

  always_comb begin
    strb.wrEn  = allocValid && !flushAll;
    strb.wrIdx = IDX_MAX_W'(pickIdx);
    strb.flush = flushAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrQ <= '0;
    end else if (flushAll) begin
      rrQ <= '0;
    end else if (strb.wrEn && useRr) begin
      rrQ <= (rrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      checkHit      <= 1'b0;
      checkRollback <= 1'b0;
    end else begin
      checkHit      <= checkValid && (|checkVec);
      checkRollback <= checkValid && !(|checkVec);
    end
  end

endmodule

// File: rtl/spec_addr_table.sv
module spec_addr_table
  import spec_tbl_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned REG_W   = 7,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              allocValid,
  input  logic [REG_W-1:0]  allocReg,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic [1:0]        allocSize,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [1:0]        storeSize,
  input  logic              checkValid,
  input  logic [REG_W-1:0]  checkReg,
  output logic              checkHit,
  output logic              checkRollback
);

  ctrlStrobe_t        strb;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] allocTagVec;
  logic [ENTRIES-1:0] freeVec;
  logic [ENTRIES-1:0] checkVec;

  spec_tbl_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .allocValid(allocValid),
    .checkValid(checkValid), .allocTagVec(allocTagVec), .freeVec(freeVec),
    .checkVec(checkVec), .strb(strb), .checkHit(checkHit),
    .checkRollback(checkRollback)
  );

  spec_tbl_entries #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_entries (
    .clk(clk), .rstN(rstN), .strb(strb), .allocReg(allocReg),
    .allocAddr(allocAddr), .allocSize(allocSize), .storeValid(storeValid),
    .storeAddr(storeAddr), .storeSize(storeSize), .checkReg(checkReg),
    .validVec(validVec), .allocTagVec(allocTagVec), .freeVec(freeVec),
    .checkVec(checkVec)
  );

endmodule

// File: rtl/spec_addr_table_chk.sv
module spec_addr_table_chk #(
  parameter int unsigned ENTRIES = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               flushAll,
  input logic               allocValid,
  input logic               checkValid,
  input logic               checkHit,
  input logic               checkRollback,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] checkVec
);

  p_resp_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(checkHit && checkRollback));

  p_check_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    checkValid |=> (checkHit || checkRollback));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> (!checkHit && !checkRollback));

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (validVec == '0));

  p_unique_tag_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(checkVec));

  p_alloc_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !flushAll) |=> (validVec != '0));

endmodule

bind spec_addr_table spec_addr_table_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .flushAll(flushAll), .allocValid(allocValid),
  .checkValid(checkValid), .checkHit(checkHit), .checkRollback(checkRollback),
  .validVec(validVec), .checkVec(checkVec)
);

// File: tb/spec_addr_table_tb.sv
module spec_addr_table_tb;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W  = 7;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              flushAll = 1'b0;
  logic              allocValid = 1'b0;
  logic [REG_W-1:0]  allocReg = '0;
  logic [ADDR_W-1:0] allocAddr = '0;
  logic [1:0]        allocSize = '0;
  logic              storeValid = 1'b0;
  logic [ADDR_W-1:0] storeAddr = '0;
  logic [1:0]        storeSize = '0;
  logic              checkValid = 1'b0;
  logic [REG_W-1:0]  checkReg = '0;
  logic              checkHit;
  logic              checkRollback;

  int totalCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_addr_table u_dut (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .allocValid(allocValid),
    .allocReg(allocReg), .allocAddr(allocAddr), .allocSize(allocSize),
    .storeValid(storeValid), .storeAddr(storeAddr), .storeSize(storeSize),
    .checkValid(checkValid), .checkReg(checkReg), .checkHit(checkHit),
    .checkRollback(checkRollback)
  );

  task automatic expect1(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    flushAll = 0; allocValid = 0; storeValid = 0; checkValid = 0;
  endtask

  task automatic doAlloc(input int r, input int a, input int s);
    allocValid = 1; allocReg = REG_W'(r); allocAddr = ADDR_W'(a); allocSize = 2'(s);
    @(negedge clk);
    drive_idle();
  endtask

  task automatic doStore(input int a, input int s);
    storeValid = 1; storeAddr = ADDR_W'(a); storeSize = 2'(s);
    @(negedge clk);
    drive_idle();
  endtask

  task automatic doFlush();
    flushAll = 1;
    @(negedge clk);
    drive_idle();
  endtask

  // Drive a check (plus whatever the caller already set), sample the answer one edge later.
  task automatic doCheck(input int r, input bit expHit, input string req);
    checkValid = 1; checkReg = REG_W'(r);
    @(negedge clk);
    expect1((checkHit == expHit) && (checkRollback == !expHit), req,
            {30'd0, checkHit, checkRollback}, {30'd0, expHit, !expHit});
    drive_idle();
  endtask

  task automatic test_reset();
    expect1(!checkHit && !checkRollback, "R1 outputs idle", {checkHit, checkRollback}, 0);
    doCheck(0, 0, "R1 empty after reset");
  endtask

  task automatic test_hit_miss();
    doFlush();
    doAlloc(12, 32'h100, 3);
    doCheck(12, 1, "R2 hit");
    doCheck(12, 1, "R2 entry kept");
    doCheck(13, 0, "R3 miss");
    @(negedge clk);
    expect1(!checkRollback && !checkHit, "R3 one cycle", {checkHit, checkRollback}, 0);
  endtask

  task automatic test_store_overlap();
    doFlush();
    doAlloc(10, 32'h2004, 2);
    doStore(32'h2006, 1);
    doCheck(10, 0, "R4 narrower store kills");
    doAlloc(10, 32'h2004, 2);
    doStore(32'h2000, 3);
    doCheck(10, 0, "R4 wider store kills");
    doAlloc(10, 32'h2004, 2);
    doStore(32'h2008, 2);
    doCheck(10, 1, "R5 adjacent above kept");
    doStore(32'h2003, 0);
    doCheck(10, 1, "R5 adjacent byte below kept");
  endtask

  task automatic test_realloc();
    doFlush();
    doAlloc(7, 32'h3000, 3);
    doAlloc(7, 32'h4000, 3);
    doStore(32'h3000, 3);
    doCheck(7, 1, "R6 old address no longer tracked");
    doStore(32'h4000, 3);
    doCheck(7, 0, "R6 new address tracked");
  endtask

  task automatic test_round_robin();
    doFlush();
    for (int i = 0; i < 32; i++) doAlloc(i, 32'h1000 + i*16, 3);
    doAlloc(32, 32'h8000, 3);
    doAlloc(33, 32'h8010, 3);
    doCheck(0, 0, "R7 entry0 replaced");
    doCheck(1, 0, "R7 entry1 replaced");
    doCheck(2, 1, "R7 entry2 kept");
    doCheck(32, 1, "R7 new reg32");
    doCheck(33, 1, "R7 new reg33");
    // free one slot, then reuse it without moving the pointer
    doStore(32'h1050, 3);
    doAlloc(40, 32'h9000, 3);
    doAlloc(41, 32'h9010, 3);
    doCheck(40, 1, "R11 freed slot used");
    doCheck(5, 0, "R11 killed entry gone");
    doCheck(41, 1, "R11 next rr victim");
    doCheck(2, 0, "R11 pointer unmoved by free alloc");
    doCheck(3, 1, "R11 neighbour kept");
  endtask

  task automatic test_store_alloc_same();
    doFlush();
    doAlloc(3, 32'h5000, 2);
    storeValid = 1; storeAddr = 32'h5000; storeSize = 2'd2;
    doAlloc(4, 32'h5000, 2);
    doCheck(4, 1, "R8 new entry survives");
    doCheck(3, 0, "R8 older entry killed");
  endtask

  task automatic test_store_check_same();
    doFlush();
    doAlloc(9, 32'h6000, 3);
    storeValid = 1; storeAddr = 32'h6004; storeSize = 2'd0;
    doCheck(9, 0, "R9 same-cycle store seen");
  endtask

  task automatic test_flush();
    doFlush();
    doAlloc(1, 32'h7000, 3);
    doAlloc(2, 32'h7008, 3);
    flushAll = 1;
    doCheck(1, 0, "R10 check with flush");
    flushAll = 1;
    doAlloc(5, 32'h7100, 3);
    doCheck(2, 0, "R10 flush cleared");
    doCheck(5, 0, "R10 alloc with flush dropped");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++; totalCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    test_reset();
    test_hit_miss();
    test_store_overlap();
    test_realloc();
    test_round_robin();
    test_store_alloc_same();
    test_store_check_same();
    test_flush();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule